// File: doc/BRIEF.md
# Interval and Watchdog Timer

This block is an 8-bit up-counter clocked by one of eight prescaled versions of the system clock. One counter serves two uses. In interval mode each wrap of the counter latches a status flag, and that flag drives an interrupt request until software clears it. In watchdog mode each wrap produces a single-cycle overflow pulse, so software must reload the counter before it wraps. The counter keeps running in both modes.

Software reaches the block through a small register port with two addresses: a control/status byte and the counter itself. Both are written with 16-bit writes whose upper byte must carry a fixed key, and each register has its own key. Any write without the right key is dropped, so a stray store cannot retune, stop or reload the timer. To clear the status flag, software must first read it as set and then write 0 to it.

Top module: `ivwd_timer`

## Requirements
- R1: After reset, the control/status byte (address 0) reads 0x18, the counter (address 1) reads 0x00, and both `irq_interval` and `wdog_ovf` are low.
- R2: The control byte's bits 2:0 select the count period in system clocks: code 0 is 2, then 64, 128, 512, 2048, 8192, 32768, and code 7 is 131072. While enabled, the counter advances by one once per selected period.
- R3: While the run bit (bit 5) is 0, the counter holds 0x00, keyed counter writes are dropped and the prescaler stays cleared. After a keyed write sets the run bit, the first increment comes exactly one full selected period after that write's clock edge.
- R4: In interval mode (bit 6 = 0), a wrap from 0xFF to 0x00 sets the status flag (bit 7). `irq_interval` is high exactly while the flag is set and interval mode is selected.
- R5: In watchdog mode (bit 6 = 1), a wrap drives `wdog_ovf` high for one cycle, in the cycle where the counter first reads 0x00. The status flag is left unchanged and the counter keeps counting.
- R6: The status flag clears only when a read of address 0 that returns the flag as 1 is followed by a keyed control write with bit 7 = 0. A keyed write of 0 with no such read before it, or a write of 1, leaves the flag set. Any keyed control write uses up the armed read.
- R7: A write to address 0 updates the mode, run and clock-select fields only when bits 15:8 of the write data equal 0xA5. Any other key leaves the byte unchanged.
- R8: A write to address 1 whose bits 15:8 equal 0x5A loads bits 7:0 into the counter. This load overrides a coincident increment and suppresses that increment's wrap. A write to address 1 with any other key leaves the counter unchanged.
- R9: Bits 4 and 3 of the control byte always read as 1, whatever value was written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 1 | 0 = control/status byte, 1 = counter |
| bus_wdata | input | 16 | Write data: bits 15:8 key, bits 7:0 value |
| bus_rdata | output | 8 | Read data for the register selected by `bus_addr` |
| irq_interval | output | 1 | Interval interrupt request, level |
| wdog_ovf | output | 1 | Watchdog overflow, one-cycle pulse |

## Verification
On every cycle, the bound checker confirms four things. The control fields change only after a keyed write to address 0. The counter leaves its +1 path only through a keyed load or while stopped. The flag rises only on a true 0xFF to 0x00 wrap and falls only after an armed read. Each watchdog pulse is one cycle wide and lines up with a wrap. The bench's scenarios cover what a property cannot express from local state: the exact cycle of the first increment after enabling for several clock-select codes, the full read-then-write clearing order against look-alike sequences, and the counter carrying on after a watchdog overflow.

// File: rtl/ivwd_pkg.sv
package ivwd_pkg;

   localparam int NUM_TAPS = 8;
   localparam int MAX_EXP  = 17;

   typedef struct packed {
      logic       wd_mode;
      logic       run;
      logic [2:0] clk_sel;
   } tmr_ctrl_t;

   // log2 of the prescale ratio for each clock-select code
   function automatic int tap_exponent(input int code);
      case (code)
         0:       return 1;
         1:       return 6;
         2:       return 7;
         3:       return 9;
         4:       return 11;
         5:       return 13;
         6:       return 15;
         default: return 17;
      endcase
   endfunction

endpackage

// File: rtl/ivwd_prescaler.sv
module ivwd_prescaler
   import ivwd_pkg::*;
#(
   parameter int PRE_W = 17
)(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run,
   input  logic [2:0] clk_sel,
   output logic       tick
);

   if (PRE_W < MAX_EXP) begin : g_width_check
      $error("ivwd_prescaler: PRE_W must cover the widest tap");
   end

   logic [PRE_W-1:0]    pre_q;
   logic [NUM_TAPS-1:0] tap_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_q <= '0;
      end else if (!run) begin
         pre_q <= '0;
      end else begin
         pre_q <= pre_q + 1'b1;
      end
   end

   // one terminal-count detector per tap; a tap fires when its low bits are all ones
   for (genvar t = 0; t < NUM_TAPS; t++) begin : g_tap
      localparam int EXP = tap_exponent(t);
      assign tap_hit[t] = &pre_q[EXP-1:0];
   end

   assign tick = run & tap_hit[clk_sel];

endmodule

// File: rtl/ivwd_counter.sv
module ivwd_counter #(
   parameter int CNT_W = 8
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             tick,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic [CNT_W-1:0] cnt,
   output logic             wrap
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!run) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (tick) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign cnt  = cnt_q;
   assign wrap = run & tick & ~load & (&cnt_q);

endmodule

// File: rtl/ivwd_ctrl_regs.sv
module ivwd_ctrl_regs
   import ivwd_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      ctrl_wr,
   input  tmr_ctrl_t wr_fields,
   input  logic      wr_flag_bit,
   input  logic      rd_ctrl,
   input  logic      wrap,
   output tmr_ctrl_t ctrl,
   output logic      flag,
   output logic      armed
);

   tmr_ctrl_t ctrl_q;
   logic      flag_q;
   logic      armed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '{wd_mode: 1'b0, run: 1'b0, clk_sel: 3'd0};
      end else if (ctrl_wr) begin
         ctrl_q <= wr_fields;
      end
   end

   // a wrap in interval mode wins over a clear in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
      end else if (wrap && !ctrl_q.wd_mode) begin
         flag_q <= 1'b1;
      end else if (ctrl_wr && !wr_flag_bit && armed_q) begin
         flag_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
      end else if (ctrl_wr) begin
         armed_q <= 1'b0;
      end else if (rd_ctrl && flag_q) begin
         armed_q <= 1'b1;
      end
   end

   assign ctrl  = ctrl_q;
   assign flag  = flag_q;
   assign armed = armed_q;

endmodule

// File: rtl/ivwd_timer.sv
module ivwd_timer
   import ivwd_pkg::*;
#(
   parameter int         CNT_W    = 8,
   parameter int         PRE_W    = 17,
   parameter logic [7:0] CTRL_KEY = 8'hA5,
   parameter logic [7:0] CNT_KEY  = 8'h5A
)(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        bus_sel,
   input  logic        bus_wr,
   input  logic        bus_addr,
   input  logic [15:0] bus_wdata,
   output logic [7:0]  bus_rdata,
   output logic        irq_interval,
   output logic        wdog_ovf
);

   if (CNT_W != 8) begin : g_cnt_check
      $error("ivwd_timer: counter must match the 8-bit register port");
   end
   if (CTRL_KEY == CNT_KEY) begin : g_key_check
      $error("ivwd_timer: the two write keys must differ");
   end

   logic [7:0]       wr_key;
   logic             ctrl_wr;
   logic             cnt_wr;
   logic             rd_ctrl;
   logic             tick;
   logic             wrap;
   logic [CNT_W-1:0] tmr_cnt;
   tmr_ctrl_t        ctrl_q;
   tmr_ctrl_t        wr_fields;
   logic             ovf_flag;
   logic             clr_armed;
   logic             wdog_q;

   assign wr_key  = bus_wdata[15:8];
   assign ctrl_wr = bus_sel & bus_wr & ~bus_addr & (wr_key == CTRL_KEY);
   assign cnt_wr  = bus_sel & bus_wr &  bus_addr & (wr_key == CNT_KEY);
   assign rd_ctrl = bus_sel & ~bus_wr & ~bus_addr;

   assign wr_fields = '{wd_mode: bus_wdata[6], run: bus_wdata[5], clk_sel: bus_wdata[2:0]};

   ivwd_ctrl_regs u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .ctrl_wr     (ctrl_wr),
      .wr_fields   (wr_fields),
      .wr_flag_bit (bus_wdata[7]),
      .rd_ctrl     (rd_ctrl),
      .wrap        (wrap),
      .ctrl        (ctrl_q),
      .flag        (ovf_flag),
      .armed       (clr_armed)
   );

   ivwd_prescaler #(.PRE_W(PRE_W)) u_pre (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (ctrl_q.run),
      .clk_sel (ctrl_q.clk_sel),
      .tick    (tick)
   );

   ivwd_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (ctrl_q.run),
      .tick     (tick),
      .load     (cnt_wr),
      .load_val (bus_wdata[CNT_W-1:0]),
      .cnt      (tmr_cnt),
      .wrap     (wrap)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wdog_q <= 1'b0;
      end else begin
         wdog_q <= wrap & ctrl_q.wd_mode;
      end
   end

   assign wdog_ovf     = wdog_q;
   assign irq_interval = ovf_flag & ~ctrl_q.wd_mode;
   assign bus_rdata    = bus_addr ? tmr_cnt
                                  : {ovf_flag, ctrl_q.wd_mode, ctrl_q.run, 2'b11, ctrl_q.clk_sel};

endmodule

module ivwd_timer_chk
   import ivwd_pkg::*;
#(
   parameter int         CNT_W    = 8,
   parameter logic [7:0] CTRL_KEY = 8'hA5,
   parameter logic [7:0] CNT_KEY  = 8'h5A
)(
   input logic             clk,
   input logic             rst_n,
   input logic             bus_sel,
   input logic             bus_wr,
   input logic             bus_addr,
   input logic [7:0]       wr_key,
   input logic             wr_flag_bit,
   input logic             irq_interval,
   input logic             wdog_ovf,
   input logic [CNT_W-1:0] tmr_cnt,
   input tmr_ctrl_t        ctrl_q,
   input logic             ovf_flag,
   input logic             clr_armed
);

   assert_stopped_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_q.run && !$past(ctrl_q.run)) |-> (tmr_cnt == '0));

   assert_flag_on_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf_flag) |-> ($past(tmr_cnt) == '1 && tmr_cnt == '0 && !$past(ctrl_q.wd_mode)));

   assert_irq_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_interval) |-> ($rose(ovf_flag) || $fell(ctrl_q.wd_mode)));

   assert_wdog_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      wdog_ovf |=> !wdog_ovf);

   assert_wdog_on_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
      wdog_ovf |-> (tmr_cnt == '0 && $past(tmr_cnt) == '1 && !$rose(ovf_flag)));

   assert_flag_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ovf_flag) |-> ($past(clr_armed) && $past(bus_sel && bus_wr && !bus_addr
                                                     && wr_key == CTRL_KEY && !wr_flag_bit)));

   assert_ctrl_keyed_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(ctrl_q) |-> $past(bus_sel && bus_wr && !bus_addr && wr_key == CTRL_KEY));

   assert_cnt_keyed_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(ctrl_q.run) && tmr_cnt != $past(tmr_cnt) && tmr_cnt != ($past(tmr_cnt) + CNT_W'(1)))
      |-> $past(bus_sel && bus_wr && bus_addr && wr_key == CNT_KEY));

endmodule

bind ivwd_timer ivwd_timer_chk #(
   .CNT_W    (CNT_W),
   .CTRL_KEY (CTRL_KEY),
   .CNT_KEY  (CNT_KEY)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .bus_sel      (bus_sel),
   .bus_wr       (bus_wr),
   .bus_addr     (bus_addr),
   .wr_key       (bus_wdata[15:8]),
   .wr_flag_bit  (bus_wdata[7]),
   .irq_interval (irq_interval),
   .wdog_ovf     (wdog_ovf),
   .tmr_cnt      (tmr_cnt),
   .ctrl_q       (ctrl_q),
   .ovf_flag     (ovf_flag),
   .clr_armed    (clr_armed)
);

// File: tb/tb_ivwd_timer.sv
module tb_ivwd_timer;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic        bus_addr = 1'b0;
   logic [15:0] bus_wdata = 16'h0000;
   logic [7:0]  bus_rdata;
   logic        irq_interval;
   logic        wdog_ovf;

   always #10 clk = ~clk;

   ivwd_timer dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .bus_sel      (bus_sel),
      .bus_wr       (bus_wr),
      .bus_addr     (bus_addr),
      .bus_wdata    (bus_wdata),
      .bus_rdata    (bus_rdata),
      .irq_interval (irq_interval),
      .wdog_ovf     (wdog_ovf)
   );

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 0;

   // behavioural reference state
   int m_pre  = 0;
   int m_cnt  = 0;
   bit m_flag = 0;
   bit m_mode = 0;
   bit m_en   = 0;
   int m_cks  = 0;
   bit m_arm  = 0;
   bit m_wd   = 0;

   function automatic int ratio(input int code);
      int r;
      case (code)
         0: r = 2;       1: r = 64;      2: r = 128;     3: r = 512;
         4: r = 2048;    5: r = 8192;    6: r = 32768;   default: r = 131072;
      endcase
      return r;
   endfunction

   task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   always @(posedge clk) begin
      int  d;
      bit  tk, kw, cw, rd, ov, nflag, narm;
      if (!rst_n) begin
         m_pre = 0; m_cnt = 0; m_flag = 0; m_mode = 0;
         m_en = 0; m_cks = 0; m_arm = 0; m_wd = 0;
      end else begin
         d  = ratio(m_cks);
         tk = m_en && ((m_pre % d) == d - 1);
         kw = bus_sel && bus_wr && !bus_addr && bus_wdata[15:8] == 8'hA5;
         cw = bus_sel && bus_wr && bus_addr && bus_wdata[15:8] == 8'h5A;
         rd = bus_sel && !bus_wr && !bus_addr;
         ov = tk && m_cnt == 255 && !cw;
         m_wd = ov && m_mode;
         nflag = m_flag;
         if (ov && !m_mode) nflag = 1;
         else if (kw && !bus_wdata[7] && m_arm) nflag = 0;
         narm = m_arm;
         if (kw) narm = 0;
         else if (rd && m_flag) narm = 1;
         if (!m_en) m_cnt = 0;
         else if (cw) m_cnt = int'(bus_wdata[7:0]);
         else if (tk) m_cnt = (m_cnt + 1) % 256;
         m_pre = m_en ? (m_pre + 1) % 131072 : 0;
         m_flag = nflag;
         m_arm  = narm;
         if (kw) begin
            m_mode = bus_wdata[6];
            m_en   = bus_wdata[5];
            m_cks  = int'(bus_wdata[2:0]);
         end
      end
   end

   // per-cycle comparison against the reference model
   always @(negedge clk) begin
      logic [7:0] exp_rd;
      #2;
      if (rst_n && !done) begin
         exp_rd = bus_addr ? 8'(m_cnt) : {m_flag, m_mode, m_en, 2'b11, 3'(m_cks)};
         check("cycle model R2 R3 R4 R5 R8",
               {6'd0, irq_interval, wdog_ovf, bus_rdata},
               {6'd0, m_flag && !m_mode, m_wd, exp_rd});
      end
   end

   task automatic bus_write(input logic a, input logic [15:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk);
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic a, output logic [7:0] v);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1 v = bus_rdata;
      @(posedge clk);
      @(negedge clk);
      bus_sel = 1'b0;
   endtask

   task automatic peek(input logic a, output logic [7:0] v);
      bus_addr = a;
      #1 v = bus_rdata;
   endtask

   task automatic finish_run();
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog R1: got timeout expected completion");
      finish_run();
   end

   initial begin
      logic [7:0] v;
      int pulses;
      int high_run;

      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      peek(1'b0, v); check("R1 ctrl reset", {8'd0, v}, 16'h0018);
      peek(1'b1, v); check("R1 cnt reset", {8'd0, v}, 16'h0000);
      check("R1 outputs low", {14'd0, irq_interval, wdog_ovf}, 16'h0000);

      // R7: unkeyed or wrongly keyed control writes are dropped
      bus_write(1'b0, 16'h1325);
      peek(1'b0, v); check("R7 bad key", {8'd0, v}, 16'h0018);
      bus_write(1'b0, 16'h5A25);
      peek(1'b0, v); check("R7 counter key on ctrl", {8'd0, v}, 16'h0018);

      // R7, R3: enable with divide-by-2, first step one full period later
      bus_write(1'b0, 16'hA520);
      peek(1'b0, v); check("R7 keyed write", {8'd0, v}, 16'h0038);
      peek(1'b1, v); check("R3 count after enable", {8'd0, v}, 16'h0000);
      @(negedge clk);
      peek(1'b1, v); check("R3 before first period", {8'd0, v}, 16'h0000);
      @(negedge clk);
      peek(1'b1, v); check("R3 first step", {8'd0, v}, 16'h0001);

      // R4: wrap at 256 * 2 cycles after enabling
      repeat (509) @(negedge clk);
      peek(1'b1, v); check("R4 before wrap", {8'd0, v}, 16'h00FF);
      check("R4 no irq yet", {15'd0, irq_interval}, 16'h0000);
      @(negedge clk);
      peek(1'b1, v); check("R4 wrapped", {8'd0, v}, 16'h0000);
      peek(1'b0, v); check("R4 flag set", {8'd0, v}, 16'h00B8);
      check("R4 irq high", {15'd0, irq_interval}, 16'h0001);
      check("R5 no wdog in interval mode", {15'd0, wdog_ovf}, 16'h0000);

      // R6: write 0 without prior read leaves the flag
      bus_write(1'b0, 16'hA520);
      peek(1'b0, v); check("R6 no read before clear", {15'd0, v[7]}, 16'h0001);
      bus_read(1'b0, v); check("R6 read shows flag", {8'd0, v}, 16'h00B8);
      bus_write(1'b0, 16'hA5A0);
      peek(1'b0, v); check("R6 writing one no effect", {15'd0, v[7]}, 16'h0001);
      bus_read(1'b0, v);
      bus_write(1'b0, 16'hA520);
      peek(1'b0, v); check("R6 cleared", {8'd0, v}, 16'h0038);
      check("R6 irq dropped", {15'd0, irq_interval}, 16'h0000);

      // R9, R8: reserved bits, keyed counter loads
      bus_write(1'b0, 16'hA527);
      peek(1'b0, v); check("R9 reserved read one", {8'd0, v}, 16'h003F);
      bus_write(1'b1, 16'h5AF0);
      peek(1'b1, v); check("R8 keyed load", {8'd0, v}, 16'h00F0);
      bus_write(1'b1, 16'h1233);
      peek(1'b1, v); check("R8 bad key ignored", {8'd0, v}, 16'h00F0);
      bus_write(1'b1, 16'hA533);
      peek(1'b1, v); check("R8 ctrl key on counter ignored", {8'd0, v}, 16'h00F0);

      // R3: stopped counter holds zero and ignores loads
      bus_write(1'b0, 16'hA507);
      @(negedge clk);
      peek(1'b1, v); check("R3 stopped zero", {8'd0, v}, 16'h0000);
      bus_write(1'b1, 16'h5A77);
      @(negedge clk);
      peek(1'b1, v); check("R3 load while stopped", {8'd0, v}, 16'h0000);

      // R2: divide-by-64
      bus_write(1'b0, 16'hA521);
      repeat (191) @(negedge clk);
      peek(1'b1, v); check("R2 div64 before third", {8'd0, v}, 16'h0002);
      @(negedge clk);
      peek(1'b1, v); check("R2 div64 third", {8'd0, v}, 16'h0003);

      // R2: divide-by-128
      bus_write(1'b0, 16'hA501);
      bus_write(1'b0, 16'hA522);
      repeat (255) @(negedge clk);
      peek(1'b1, v); check("R2 div128 before second", {8'd0, v}, 16'h0001);
      @(negedge clk);
      peek(1'b1, v); check("R2 div128 second", {8'd0, v}, 16'h0002);

      // R2: divide-by-512
      bus_write(1'b0, 16'hA502);
      bus_write(1'b0, 16'hA523);
      repeat (511) @(negedge clk);
      peek(1'b1, v); check("R2 div512 before first", {8'd0, v}, 16'h0000);
      @(negedge clk);
      peek(1'b1, v); check("R2 div512 first", {8'd0, v}, 16'h0001);

      // R5: watchdog mode, preload near the top
      bus_write(1'b0, 16'hA500);
      bus_write(1'b0, 16'hA560);
      bus_write(1'b1, 16'h5AFE);
      pulses = 0;
      high_run = 0;
      for (int i = 0; i < 300; i++) begin
         @(negedge clk);
         if (wdog_ovf) begin
            pulses++;
            high_run++;
            peek(1'b1, v); check("R5 pulse at zero", {8'd0, v}, 16'h0000);
            peek(1'b0, v); check("R5 flag untouched", {15'd0, v[7]}, 16'h0000);
            check("R5 no irq", {15'd0, irq_interval}, 16'h0000);
         end else begin
            if (high_run > 1) check("R5 pulse width", 16'(high_run), 16'd1);
            high_run = 0;
         end
      end
      check("R5 one overflow", 16'(pulses), 16'd1);
      peek(1'b1, v); check("R5 keeps counting", {15'd0, v != 8'h00}, 16'h0001);

      @(negedge clk);
      finish_run();
   end

endmodule